// File: doc/BRIEF.md
# Cache Slice Event Counter Unit

This block counts activity inside one slice of a shared cache. Eight 32-bit counters each pick what to count through an 8-bit selector. A counter can count clock cycles, or it can count one of six single-cycle strobes that the cache raises for read hits, read misses, data-side read hits, data-side read misses, write hits and write misses. Software reaches every control and every counter value through a flat 32-bit register bus. A write completes at the clock edge in which it is presented. A read returns data combinationally in the same cycle.

Software can chain an even counter to the odd counter just above it, which forms one 64-bit counter. The odd counter then holds the upper half and counts carries out of the even counter. Each counter has a sticky overflow flag. The flag normally latches when the counter wraps past all-ones. An optional mode also latches it whenever the counter's top bit changes, so a 32-bit counter can be left free-running and software can still learn that half of its range has passed. A single interrupt line is asserted while any flagged counter also has its interrupt enabled.

Top module: `cache_evt_pmu`

## Requirements
- R1: After the synchronous reset input, every register reads zero and `irq` is low.
- R2: The event type register of counter i is at 0x220+8*i, and its low 8 bits are the selector. Code 0x01 counts every enabled cycle. Code 0x20+k counts the cycles in which `ev_strobe[k]` is high, for k from 0 to 5, with 0x20 read hit, 0x21 read miss, 0x22 data read hit, 0x23 data read miss, 0x24 write hit and 0x25 write miss. Every other code, including 0, counts nothing.
- R3: Bit 0 of the control register at 0x500 is the unit-wide count enable. While it is 0, no counter advances.
- R4: Writing 1s to 0x508 sets counter enable bits, and writing 1s to 0x50C clears them. Interrupt enables work the same way through 0x510 (set) and 0x514 (clear). Bit i belongs to counter i, and both addresses of a pair read back the current mask.
- R5: Counter i is read and written at 0x420+8*i. A write takes effect at its clock edge and overrides an increment in the same cycle. A read returns the value held at the end of the previous cycle.
- R6: In the gang register at 0x718, setting odd bit i makes counter i ignore its own selector and advance only when counter i-1 wraps from all-ones to zero. Even bits always read 0 and have no effect.
- R7: Status register 0x740 bit i is set when counter i wraps from all-ones to zero. The bit stays set until a 1 is written to it, and writing 0 bits leaves it unchanged.
- R8: When bit i of 0x96C is set, status bit i is also set whenever an increment changes bit 31 of counter i, in either direction. When bit i is clear, a 0-to-1 change of bit 31 does not set status bit i.
- R9: `irq` is high exactly while some status bit and its interrupt enable bit are both set. Clearing the status bit drops it.
- R10: Writing 1 to bit 1 of 0x500 clears every counter value, counter enable, interrupt enable, gang bit, MSB-toggle bit and status bit. Event type registers keep their values. Bit 1 reads 1 for the one cycle after the write and 0 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the same cycle as a read request |
| ev_strobe | input | 6 | Cache event strobes, one per event kind |
| irq | output | 1 | Overflow interrupt |

## Verification
The embedded properties check the following on every cycle:
- A counter with no count enable and no write holds its value.
- A counter write lands exactly, and the reset pulse zeroes all counters.
- A ganged upper counter steps exactly on its partner's carry.
- Status bits never drop without a clear.
- The interrupt only falls after a software action.

Only the bench scenarios can show the following, because they need programmed register sequences and known strobe patterns:
- Which selector codes count and which count nothing.
- The exact counts produced over a gated window.
- That a write beats a same-cycle increment.
- That the MSB-toggle mode flags a 0-to-1 change while the plain mode does not.
- That event types survive the soft reset.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_CTRL    = 12'h500;
    localparam logic [BUS_AW-1:0] OFS_CNT     = 12'h420;
    localparam logic [BUS_AW-1:0] OFS_EVT     = 12'h220;
    localparam logic [BUS_AW-1:0] OFS_EN_SET  = 12'h508;
    localparam logic [BUS_AW-1:0] OFS_EN_CLR  = 12'h50C;
    localparam logic [BUS_AW-1:0] OFS_IE_SET  = 12'h510;
    localparam logic [BUS_AW-1:0] OFS_IE_CLR  = 12'h514;
    localparam logic [BUS_AW-1:0] OFS_GANG    = 12'h718;
    localparam logic [BUS_AW-1:0] OFS_STATUS  = 12'h740;
    localparam logic [BUS_AW-1:0] OFS_MSBTOG  = 12'h96C;
    localparam int unsigned       SLOT_STRIDE = 8;

    localparam logic [7:0] CODE_CYCLES  = 8'h01;
    localparam logic [7:0] CODE_EV_BASE = 8'h20;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_req_t;

    function automatic logic [BUS_AW-1:0] slot_addr(logic [BUS_AW-1:0] base, int unsigned idx);
        return base + BUS_AW'(idx * SLOT_STRIDE);
    endfunction

    function automatic logic [31:0] odd_bits(int unsigned n);
        logic [31:0] m;
        m = '0;
        for (int unsigned b = 0; b < n; b++) begin
            m[b] = b[0];
        end
        return m;
    endfunction

endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_EV = 6
) (
    input  logic [7:0]        code,
    input  logic [NUM_EV-1:0] ev,
    output logic              hit
);
    always_comb begin
        hit = 1'b0;
        if (code == CODE_CYCLES) begin
            hit = 1'b1;
        end
        for (int unsigned k = 0; k < NUM_EV; k++) begin
            if (code == CODE_EV_BASE + 8'(k)) begin
                hit = ev[k];
            end
        end
    end
endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         count_en,
    input  logic         hit,
    input  logic         use_carry,
    input  logic         carry_in,
    input  logic         msb_mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         carry_out,
    output logic         ovf_evt
);
    logic step;
    logic inc;
    logic low_full;

    assign step      = count_en & (use_carry ? carry_in : hit);
    assign inc       = step & ~wr_en & ~clr;
    assign low_full  = &value[W-2:0];
    assign carry_out = inc & low_full & value[W-1];
    assign ovf_evt   = carry_out | (msb_mode & inc & low_full);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end else if (inc) begin
            value <= value + W'(1);
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !wr_en && !clr) |=> $stable(value));

    p_write_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> (value == $past(wr_data)));

    p_gang_step_r6: assert property (@(posedge clk) disable iff (rst)
        (use_carry && count_en && carry_in && !wr_en && !clr) |=> (value == $past(value) + W'(1)));

    p_soft_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0));
endmodule

// File: rtl/cache_evt_pmu.sv
module cache_evt_pmu
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_CNT = 8,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_EV  = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [BUS_AW-1:0]   req_addr,
    input  logic [BUS_DW-1:0]   req_wdata,
    output logic [BUS_DW-1:0]   rd_data,
    input  logic [NUM_EV-1:0]   ev_strobe,
    output logic                irq
);
    localparam logic [NUM_CNT-1:0] GANG_MASK = NUM_CNT'(odd_bits(NUM_CNT));

    bus_req_t req;
    assign req = '{valid: req_valid, write: req_write, addr: req_addr, data: req_wdata};

    logic wr, rd;
    assign wr = req.valid &  req.write;
    assign rd = req.valid & ~req.write;

    logic ctrl_wr, en_set_wr, en_clr_wr, ie_set_wr, ie_clr_wr;
    logic gang_wr, stat_wr, msb_wr;
    assign ctrl_wr   = wr && req.addr == OFS_CTRL;
    assign en_set_wr = wr && req.addr == OFS_EN_SET;
    assign en_clr_wr = wr && req.addr == OFS_EN_CLR;
    assign ie_set_wr = wr && req.addr == OFS_IE_SET;
    assign ie_clr_wr = wr && req.addr == OFS_IE_CLR;
    assign gang_wr   = wr && req.addr == OFS_GANG;
    assign stat_wr   = wr && req.addr == OFS_STATUS;
    assign msb_wr    = wr && req.addr == OFS_MSBTOG;

    logic [NUM_CNT-1:0] wmask;
    assign wmask = req.data[NUM_CNT-1:0];

    logic               glob_en_q, rst_q, clr;
    logic [NUM_CNT-1:0] cnt_en_q, int_en_q, gang_q, msb_q, ovf_q;
    logic [7:0]         evsel_q [NUM_CNT];
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0] carry, ovf_evt, hit, cnt_wr;

    assign clr = (ctrl_wr & req.data[1]) | rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en_q <= 1'b0;
            rst_q     <= 1'b0;
        end else begin
            rst_q <= ctrl_wr & req.data[1];
            if (ctrl_wr) glob_en_q <= req.data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_en_q <= '0;
            int_en_q <= '0;
            gang_q   <= '0;
            msb_q    <= '0;
            ovf_q    <= '0;
        end else begin
            if (en_set_wr) cnt_en_q <= cnt_en_q | wmask;
            if (en_clr_wr) cnt_en_q <= cnt_en_q & ~wmask;
            if (ie_set_wr) int_en_q <= int_en_q | wmask;
            if (ie_clr_wr) int_en_q <= int_en_q & ~wmask;
            if (gang_wr)   gang_q   <= wmask & GANG_MASK;
            if (msb_wr)    msb_q    <= wmask;
            ovf_q <= (ovf_q & ~(stat_wr ? wmask : '0)) | ovf_evt;
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic evt_wr;
        assign evt_wr    = wr && req.addr == slot_addr(OFS_EVT, i);
        assign cnt_wr[i] = wr && req.addr == slot_addr(OFS_CNT, i);

        always_ff @(posedge clk) begin
            if (rst) begin
                evsel_q[i] <= '0;
            end else if (evt_wr) begin
                evsel_q[i] <= req.data[7:0];
            end
        end

        pmu_event_sel #(.NUM_EV(NUM_EV)) u_sel (
            .code (evsel_q[i]),
            .ev   (ev_strobe),
            .hit  (hit[i])
        );

        logic use_c, c_in;
        if (i % 2 == 1) begin : g_odd
            assign use_c = gang_q[i];
            assign c_in  = carry[i-1];
        end else begin : g_even
            assign use_c = 1'b0;
            assign c_in  = 1'b0;
        end

        pmu_counter_slice #(.W(CNT_W)) u_slice (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr),
            .count_en  (glob_en_q & cnt_en_q[i] & ~rst_q),
            .hit       (hit[i]),
            .use_carry (use_c),
            .carry_in  (c_in),
            .msb_mode  (msb_q[i]),
            .wr_en     (cnt_wr[i]),
            .wr_data   (req.data[CNT_W-1:0]),
            .value     (cnt_val[i]),
            .carry_out (carry[i]),
            .ovf_evt   (ovf_evt[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd) begin
            unique case (req.addr)
                OFS_CTRL:               rd_data = {30'd0, rst_q, glob_en_q};
                OFS_EN_SET, OFS_EN_CLR: rd_data = BUS_DW'(cnt_en_q);
                OFS_IE_SET, OFS_IE_CLR: rd_data = BUS_DW'(int_en_q);
                OFS_GANG:               rd_data = BUS_DW'(gang_q);
                OFS_STATUS:             rd_data = BUS_DW'(ovf_q);
                OFS_MSBTOG:             rd_data = BUS_DW'(msb_q);
                default:                rd_data = '0;
            endcase
            for (int unsigned i = 0; i < NUM_CNT; i++) begin
                if (req.addr == slot_addr(OFS_CNT, i)) rd_data = BUS_DW'(cnt_val[i]);
                if (req.addr == slot_addr(OFS_EVT, i)) rd_data = BUS_DW'(evsel_q[i]);
            end
        end
    end

    assign irq = |(ovf_q & int_en_q);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (!stat_wr && !clr) |=> (($past(ovf_q) & ~ovf_q) == '0));

    p_irq_drop_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(stat_wr || ie_clr_wr || clr));

    p_gang_even_r6: assert property (@(posedge clk) disable iff (rst)
        gang_wr |=> ((gang_q & ~GANG_MASK) == '0));
endmodule

// File: tb/sim_cache_evt_pmu.sv
`timescale 1ns/1ps
module sim_cache_evt_pmu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [5:0]  ev_strobe = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    cache_evt_pmu u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .ev_strobe(ev_strobe), .irq(irq)
    );

    localparam logic [11:0] A_CTRL = 12'h500, A_ENS = 12'h508, A_ENC = 12'h50C,
                            A_IES = 12'h510, A_IEC = 12'h514, A_GANG = 12'h718,
                            A_STAT = 12'h740, A_MSB = 12'h96C;
    function automatic logic [11:0] a_cnt(int i); return 12'h420 + 12'(i * 8); endfunction
    function automatic logic [11:0] a_evt(int i); return 12'h220 + 12'(i * 8); endfunction

    // monitor: pops expected reads and compares them away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (req_valid && !req_write && sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.exp || req_addr !== it.addr) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, req_addr, rd_data, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        sb.push_back('{addr: a, exp: e, tag: tag});
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        ev_strobe = m;
        @(posedge clk);
        #1 ev_strobe = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] e);
        checks++;
        if (got !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        expect_rd(A_CTRL, 32'd0, "R1 ctrl");
        expect_rd(a_cnt(0), 32'd0, "R1 cnt0");
        expect_rd(A_STAT, 32'd0, "R1 status");

        // R2 event selection, R4 enable set
        bus_wr(a_evt(0), 32'h20);
        bus_wr(a_evt(1), 32'h21);
        bus_wr(a_evt(2), 32'h00);
        bus_wr(a_evt(3), 32'h07);
        bus_wr(A_ENS, 32'h0F);
        bus_wr(A_CTRL, 32'h1);
        for (int n = 0; n < 3; n++) pulse(6'b000001);
        for (int n = 0; n < 2; n++) pulse(6'b000010);
        pulse(6'b111111);
        expect_rd(a_cnt(0), 32'd4, "R2 read-hit count");
        expect_rd(a_cnt(1), 32'd3, "R2 read-miss count");
        expect_rd(a_cnt(2), 32'd0, "R2 code 0 counts nothing");
        expect_rd(a_cnt(3), 32'd0, "R2 unused code counts nothing");
        expect_rd(a_evt(0), 32'h20, "R2 event type readback");
        expect_rd(A_ENS, 32'h0F, "R4 enable mask");

        // R3 global disable
        bus_wr(A_CTRL, 32'h0);
        for (int n = 0; n < 3; n++) pulse(6'b111111);
        expect_rd(a_cnt(0), 32'd4, "R3 no count when disabled");

        // R2 cycles code over a gated window: 5 idle + 1 = 6 counts
        bus_wr(a_evt(4), 32'h01);
        bus_wr(A_ENS, 32'h10);
        bus_wr(A_CTRL, 32'h1);
        repeat (5) @(posedge clk);
        bus_wr(A_CTRL, 32'h0);
        expect_rd(a_cnt(4), 32'd6, "R2 cycle count");
        bus_wr(A_ENC, 32'h10);

        // R4 enable clear
        bus_wr(A_ENC, 32'h01);
        expect_rd(A_ENC, 32'h0E, "R4 mask after clear");
        bus_wr(A_CTRL, 32'h1);
        pulse(6'b000001);
        bus_wr(A_CTRL, 32'h0);
        expect_rd(a_cnt(0), 32'd4, "R4 cleared counter holds");

        // R5 write beats increment
        bus_wr(a_evt(5), 32'h01);
        bus_wr(A_ENS, 32'h20);
        bus_wr(A_CTRL, 32'h1);
        bus_wr(a_cnt(5), 32'd100);
        bus_wr(A_CTRL, 32'h0);
        expect_rd(a_cnt(5), 32'd101, "R5 write priority");
        bus_wr(A_ENC, 32'h20);

        // R7 wrap overflow, R9 irq
        bus_wr(a_cnt(1), 32'hFFFF_FFFF);
        bus_wr(A_CTRL, 32'h1);
        pulse(6'b000010);
        expect_rd(a_cnt(1), 32'd0, "R7 wrap to zero");
        expect_rd(A_STAT, 32'h02, "R7 status on wrap");
        chk("R9 irq low without enable", {31'd0, irq}, 32'd0);
        bus_wr(A_IES, 32'h02);
        chk("R9 irq high", {31'd0, irq}, 32'd1);
        expect_rd(A_IES, 32'h02, "R4 int enable mask");
        bus_wr(A_STAT, 32'h00);
        expect_rd(A_STAT, 32'h02, "R7 sticky on zero write");
        bus_wr(A_STAT, 32'h02);
        chk("R9 irq drops after clear", {31'd0, irq}, 32'd0);
        expect_rd(A_STAT, 32'h00, "R7 w1c");

        // R8 MSB toggle vs plain
        bus_wr(a_evt(2), 32'h22);
        bus_wr(a_evt(3), 32'h23);
        bus_wr(A_MSB, 32'h04);
        bus_wr(a_cnt(2), 32'h7FFF_FFFF);
        bus_wr(a_cnt(3), 32'h7FFF_FFFF);
        pulse(6'b001100);
        expect_rd(a_cnt(2), 32'h8000_0000, "R8 counter value");
        expect_rd(A_STAT, 32'h04, "R8 toggle flags only msb-mode counter");
        bus_wr(A_STAT, 32'h04);

        // R6 gang
        bus_wr(a_evt(6), 32'h24);
        bus_wr(a_evt(7), 32'h25);
        bus_wr(A_ENS, 32'hC0);
        bus_wr(A_GANG, 32'h80);
        bus_wr(a_cnt(6), 32'hFFFF_FFFE);
        bus_wr(a_cnt(7), 32'd5);
        pulse(6'b110000);
        expect_rd(a_cnt(6), 32'hFFFF_FFFF, "R6 low half");
        expect_rd(a_cnt(7), 32'd5, "R6 upper ignores selector");
        pulse(6'b110000);
        expect_rd(a_cnt(6), 32'd0, "R6 low wraps");
        expect_rd(a_cnt(7), 32'd6, "R6 upper takes carry");
        expect_rd(A_STAT, 32'h40, "R6 wrap flags low half");
        bus_wr(A_GANG, 32'hFF);
        expect_rd(A_GANG, 32'hAA, "R6 even gang bits read zero");

        // R10 soft reset
        bus_wr(A_IES, 32'h40);
        chk("R9 irq from gang wrap", {31'd0, irq}, 32'd1);
        bus_wr(A_CTRL, 32'h2);
        expect_rd(A_CTRL, 32'h2, "R10 reset bit visible one cycle");
        expect_rd(A_CTRL, 32'h0, "R10 reset bit self-clears");
        expect_rd(a_cnt(7), 32'd0, "R10 counter cleared");
        expect_rd(A_GANG, 32'h0, "R10 gang cleared");
        expect_rd(A_STAT, 32'h0, "R10 status cleared");
        expect_rd(A_ENS, 32'h0, "R10 enables cleared");
        expect_rd(A_IES, 32'h0, "R10 int enables cleared");
        expect_rd(A_MSB, 32'h0, "R10 msb mode cleared");
        expect_rd(a_evt(6), 32'h24, "R10 event type kept");
        chk("R10 irq low", {31'd0, irq}, 32'd0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule